// File: doc/BRIEF.md
# Multiphase Interleaved PWM Generator

This block drives up to four pulse-width-modulated outputs from one shared period counter. Each active channel sees its own phase-shifted copy of that counter (a sawtooth) and holds its output high while the sawtooth is below the channel's duty command. The channels are spread evenly across the switching period, so the combined ripple seen by a downstream stage runs at the channel rate times the number of active channels.

The number of active channels is not programmed. While reset is held, the block reads one strap bit per channel that marks the channel as unused. The active set is the run of low-numbered channels below the first strapped one, and the phase spacing follows from that count. The period value and the phase offsets are captured only during reset. Each output is a level plus a drive-enable pair, so a pad can make it high-impedance; a global tri-state input and a global output-enable shape the drive at run time.

Top module: `mpwm_top`

## Requirements
- R1: While `rstN` is low, every `pwmDrive` bit and every `pwmLevel` bit is 0.
- R2: The active count N is the index of the lowest channel whose `strapUnused` bit is 1 (1 means unused), N = 4 with no strap set, and N = 1 if channel 0 is strapped. Channels with index N or above never drive.
- R3: The counter runs 0..P-1 with P = `periodIn` captured during reset, starting from 0 on the first clock edge after reset is released. Channel k's sawtooth is (counter - floor(P*k/N)) mod P. A change of `periodIn` after reset has no effect.
- R4: With every active duty command in 1..P-1 and steady, any window of P consecutive cycles contains exactly N rising edges summed over all outputs.
- R5: On each clock edge a channel's level register takes 1 when its sawtooth is below its duty command and 0 otherwise, so the output is active high and one cycle behind the counter.
- R6: A duty command is taken only on the edge where that channel's sawtooth is 0; changes at other times have no effect until then.
- R7: While `triState` is 1, every `pwmDrive` bit and every `pwmLevel` bit is 0, in the same cycle.
- R8: While `outEn` is 0 and `triState` is 0, active channels drive (`pwmDrive` = 1) with `pwmLevel` = 0.
- R9: A duty command of 0 gives a constantly low output; a duty command of P or more gives a constantly high output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; straps and period are sampled while it is low |
| periodIn | input | CW | Switching period in clock cycles (2 or more) |
| dutyIn | input | NUM_CH*CW | Duty commands, channel k in bits k*CW +: CW |
| strapUnused | input | NUM_CH | Per-channel unused strap, 1 = unused |
| outEn | input | 1 | 0 forces active outputs to a driven low |
| triState | input | 1 | 1 releases every output to high impedance |
| pwmLevel | output | NUM_CH | Output level per channel (0 when not driven) |
| pwmDrive | output | NUM_CH | Drive enable per channel, 0 = high impedance |

## Verification
Every cycle the assertions check that the counter stays below the period and wraps to zero, that the captured period stays frozen while running, that the active mask is a contiguous low run including channel 0, that a fresh zero, nonzero or saturating duty command produces the matching level one edge later, and that nothing drives during reset. The phase offsets for each channel count, the evenly spread rising edges per period, the deferral of mid-period duty changes and the run-time effect of the tri-state and output-enable controls are shown only by the bench's scenarios, which compare every output cycle against an independently computed prediction.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  localparam int CH_MAX = 4;

  // Strobes handed from the control section to the datapath
  typedef struct packed {
    logic              run;
    logic [CH_MAX-1:0] loadDuty;
    logic [CH_MAX-1:0] active;
  } pwmStrobe_t;

endpackage

// File: rtl/mpwm_ctrl.sv
module mpwm_ctrl
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CW     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CW-1:0]                periodIn,
  input  logic [NUM_CH-1:0]            strapUnused,
  output pwmStrobe_t                   strobe,
  output logic [CW-1:0]                perReg,
  output logic [NUM_CH-1:0][CW-1:0]    phaseCnt
);

  localparam int NW = $clog2(NUM_CH + 1);
  localparam int PW = CW + NW;

  logic [NW-1:0]              nNext, nReg;
  logic [NUM_CH-1:0][CW-1:0]  offNext, offReg;
  logic [NUM_CH-1:0]          activeMask;
  logic [CW-1:0]              cnt;
  logic                       run;

  // Active count: channels below the first strapped one, at least one
  always_comb begin
    logic hit;
    hit   = 1'b0;
    nNext = NW'(NUM_CH);
    for (int k = 0; k < NUM_CH; k++) begin
      if (!hit && strapUnused[k]) begin
        nNext = NW'(k);
        hit   = 1'b1;
      end
    end
    if (nNext == '0) nNext = NW'(1);
  end

  // Phase offsets floor(P*k/N), evaluated only while reset is held
  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      offNext[k] = CW'((PW'(periodIn) * PW'(k)) / PW'(nNext));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perReg <= periodIn;
      nReg   <= nNext;
      offReg <= offNext;
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      activeMask[k] = (NW'(k) < nReg);
    end
  end

  // Shared period counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      run <= 1'b0;
    end else begin
      run <= 1'b1;
      if ((CW+1)'(cnt) + (CW+1)'(1) >= (CW+1)'(perReg)) cnt <= '0;
      else                                             cnt <= cnt + CW'(1);
    end
  end

  // Per-channel phase-shifted sawtooth
  for (genvar k = 0; k < NUM_CH; k++) begin : gPhase
    always_comb begin
      if (cnt >= offReg[k]) phaseCnt[k] = cnt - offReg[k];
      else phaseCnt[k] = CW'((CW+1)'(cnt) + (CW+1)'(perReg) - (CW+1)'(offReg[k]));
    end
  end

  always_comb begin
    strobe     = '0;
    strobe.run = run;
    for (int k = 0; k < NUM_CH; k++) begin
      strobe.active[k]   = activeMask[k];
      strobe.loadDuty[k] = activeMask[k] && (phaseCnt[k] == '0);
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (perReg != '0) |-> (cnt < perReg));

  assert_cnt_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (run && perReg > CW'(1) && cnt == perReg - CW'(1)) |=> (cnt == '0));

  assert_period_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    run |=> $stable(perReg));

  assert_active_contig_R2: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (activeMask[0] && (((activeMask + NUM_CH'(1)) & activeMask) == '0)));

endmodule

// File: rtl/mpwm_dpath.sv
module mpwm_dpath
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CW     = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pwmStrobe_t                  strobe,
  input  logic [CW-1:0]               perReg,
  input  logic [NUM_CH-1:0][CW-1:0]   phaseCnt,
  input  logic [NUM_CH*CW-1:0]        dutyIn,
  output logic [NUM_CH-1:0]           levelRaw
);

  for (genvar k = 0; k < NUM_CH; k++) begin : gChan
    logic [CW-1:0] dutyReg;
    logic [CW-1:0] dutyNow;
    logic [CW-1:0] dutyCmd;

    assign dutyCmd = dutyIn[k*CW +: CW];
    // The command in force on a period start is the fresh one
    assign dutyNow = strobe.loadDuty[k] ? dutyCmd : dutyReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dutyReg     <= '0;
        levelRaw[k] <= 1'b0;
      end else begin
        if (strobe.loadDuty[k]) dutyReg <= dutyCmd;
        levelRaw[k] <= (phaseCnt[k] < dutyNow);
      end
    end

    assert_zero_duty_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadDuty[k] && dutyCmd == '0) |=> !levelRaw[k]);

    assert_full_duty_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadDuty[k] && dutyCmd >= perReg) |=> levelRaw[k]);

    assert_start_high_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadDuty[k] && dutyCmd != '0) |=> levelRaw[k]);
  end

endmodule

// File: rtl/mpwm_top.sv
module mpwm_top
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CW     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CW-1:0]         periodIn,
  input  logic [NUM_CH*CW-1:0]  dutyIn,
  input  logic [NUM_CH-1:0]     strapUnused,
  input  logic                  outEn,
  input  logic                  triState,
  output logic [NUM_CH-1:0]     pwmLevel,
  output logic [NUM_CH-1:0]     pwmDrive
);

  pwmStrobe_t                 strobe;
  logic [CW-1:0]              perReg;
  logic [NUM_CH-1:0][CW-1:0]  phaseCnt;
  logic [NUM_CH-1:0]          levelRaw;

  mpwm_ctrl #(.NUM_CH(NUM_CH), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .strapUnused(strapUnused),
    .strobe(strobe), .perReg(perReg), .phaseCnt(phaseCnt)
  );

  mpwm_dpath #(.NUM_CH(NUM_CH), .CW(CW)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .perReg(perReg),
    .phaseCnt(phaseCnt), .dutyIn(dutyIn), .levelRaw(levelRaw)
  );

  assign pwmDrive = {NUM_CH{strobe.run & ~triState}} & strobe.active[NUM_CH-1:0];
  assign pwmLevel = levelRaw & pwmDrive & {NUM_CH{outEn}};

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (pwmDrive == '0 && pwmLevel == '0));

endmodule

// File: tb/tb_mpwm_top.sv
`timescale 1ns/1ps
module tb_mpwm_top;
  localparam int NCH = 4;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] periodIn = 8'd8;
  logic [NCH*CW-1:0] dutyIn = '0;
  logic [NCH-1:0] strapUnused = '0;
  logic outEn = 1'b1;
  logic triState = 1'b0;
  logic [NCH-1:0] pwmLevel, pwmDrive;

  int nTotal = 0;
  int nBad = 0;
  bit done = 0;
  string curTag = "R5";
  logic [NCH-1:0] expQ[$];
  int mN = NCH, mP = 8, mCnt = 0;
  int mOff[NCH];
  int mDuty[NCH];

  always #2 clk = ~clk;

  mpwm_top #(.NUM_CH(NCH), .CW(CW)) dut (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .dutyIn(dutyIn),
    .strapUnused(strapUnused), .outEn(outEn), .triState(triState),
    .pwmLevel(pwmLevel), .pwmDrive(pwmDrive)
  );

  function automatic void check(bit ok, string tag, int act, int exp);
    nTotal++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // Predictor: pushes the expected raw level vector for each running edge
  always @(posedge clk) begin : predictor
    logic [NCH-1:0] e;
    int mc;
    if (!rstN) begin
      expQ.delete();
      mCnt = 0;
      mP = int'(periodIn);
      mN = NCH;
      for (int k = NCH - 1; k >= 0; k--) if (strapUnused[k]) mN = k;
      if (mN == 0) mN = 1;
      for (int k = 0; k < NCH; k++) begin
        mOff[k] = (mP * k) / mN;
        mDuty[k] = 0;
      end
    end else begin
      e = '0;
      for (int k = 0; k < mN; k++) begin
        mc = (mCnt - mOff[k] + mP) % mP;
        if (mc == 0) mDuty[k] = int'(dutyIn[k*CW +: CW]);
        e[k] = (mc < mDuty[k]);
      end
      expQ.push_back(e);
      mCnt = (mCnt + 1 >= mP) ? 0 : mCnt + 1;
    end
  end

  // Monitor: pops and compares away from the active edge
  always @(negedge clk) begin : monitor
    logic [NCH-1:0] e;
    logic [NCH-1:0] expDrv;
    if (rstN && expQ.size() > 0) begin
      e = expQ.pop_front();
      expDrv = '0;
      for (int k = 0; k < mN; k++) expDrv[k] = !triState;
      check(pwmDrive == expDrv, {curTag, " drive"}, int'(pwmDrive), int'(expDrv));
      check(pwmLevel == (e & expDrv & {NCH{outEn}}), {curTag, " level"},
            int'(pwmLevel), int'(e & expDrv & {NCH{outEn}}));
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setDuty(int a, int b, int c, int d);
    @(negedge clk);
    #1 dutyIn = {CW'(d), CW'(c), CW'(b), CW'(a)};
  endtask

  task automatic doReset(int per, logic [NCH-1:0] strap);
    @(negedge clk);
    #1 rstN = 1'b0;
    periodIn = CW'(per);
    strapUnused = strap;
    repeat (3) @(negedge clk);
    check(pwmDrive == '0, "R1 reset drive", int'(pwmDrive), 0);
    check(pwmLevel == '0, "R1 reset level", int'(pwmLevel), 0);
    #1 rstN = 1'b1;
  endtask

  task automatic checkRipple(int cycles, int expRise, string tag);
    int rises = 0;
    logic [NCH-1:0] prev;
    @(negedge clk);
    prev = pwmLevel;
    repeat (cycles) begin
      @(negedge clk);
      rises += $countones(pwmLevel & ~prev);
      prev = pwmLevel;
    end
    check(rises == expRise, tag, rises, expRise);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", nTotal, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTotal++;
      nBad++;
      $display("FAIL watchdog (all R) actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    waitCyc(2);
    // four channels, period 8, offsets 0,2,4,6
    doReset(8, 4'b0000);
    curTag = "R3 R5";
    setDuty(1, 3, 5, 7);
    waitCyc(40);
    curTag = "R9";
    setDuty(0, 8, 200, 0);
    waitCyc(24);
    curTag = "R4";
    setDuty(3, 3, 3, 3);
    waitCyc(16);
    checkRipple(8, 4, "R4 four channels rises");
    curTag = "R6";
    for (int i = 0; i < 10; i++) begin
      setDuty(i, 7 - (i % 7), (i * 3) % 9, 2);
      waitCyc(3);
    end
    waitCyc(16);
    curTag = "R7";
    @(negedge clk);
    #1 triState = 1'b1;
    @(negedge clk);
    check(pwmDrive == '0, "R7 tristate drive", int'(pwmDrive), 0);
    check(pwmLevel == '0, "R7 tristate level", int'(pwmLevel), 0);
    waitCyc(10);
    #1 triState = 1'b0;
    curTag = "R8";
    @(negedge clk);
    #1 outEn = 1'b0;
    @(negedge clk);
    check(pwmDrive == 4'hF, "R8 disabled drive", int'(pwmDrive), 15);
    check(pwmLevel == '0, "R8 disabled level", int'(pwmLevel), 0);
    waitCyc(10);
    #1 outEn = 1'b1;
    // channel 2 strapped: two active, channel 3 stays quiet
    doReset(10, 4'b0100);
    curTag = "R2";
    setDuty(4, 4, 9, 9);
    waitCyc(30);
    check(pwmDrive == 4'b0011, "R2 two active drive", int'(pwmDrive), 3);
    checkRipple(10, 2, "R4 two channels rises");
    // every strap set: channel 0 still runs alone
    doReset(6, 4'b1111);
    curTag = "R2";
    setDuty(2, 5, 5, 5);
    waitCyc(20);
    check(pwmDrive == 4'b0001, "R2 single active drive", int'(pwmDrive), 1);
    // three active, period 12, offsets 0,4,8
    doReset(12, 4'b1000);
    curTag = "R3";
    setDuty(1, 1, 1, 1);
    waitCyc(30);
    checkRipple(12, 3, "R4 three channels rises");
    curTag = "R3 frozen period";
    @(negedge clk);
    #1 periodIn = 8'd5;
    waitCyc(30);
    done = 1;
    finishRun();
  end

endmodule